// File: doc/BRIEF.md
# Receive FIFO with level and idle-timeout interrupts

This block is the receive half of a serial port's interrupt logic, with its registers. Characters arrive from a deserializer as a one-cycle valid strobe with an 8-bit value. They are stored in a receive FIFO and read out through a data register on a simple register bus.

Two interrupt sources watch the FIFO:
- A level source fires when the fill count reaches a trigger level. Software selects the level as a fraction of the FIFO depth.
- A timeout source catches characters left below that level. It fires once they have sat untouched for an idle period counted in bit-clock ticks.

A third source flags characters that were dropped because the FIFO was full. A raw status register, a mask register, a masked status register and a write-one-to-clear register manage these sources. One interrupt line combines them.

A test mode lets the bus inject characters straight into the receive FIFO. In that mode a data-register read pops a small transmit FIFO, which is otherwise filled by normal data-register writes. The interrupt handler reads the raw status, clears it, and drains the receive FIFO until the flag register shows it empty.

Top module: `uart_rx_irq`

## Requirements
- R1: In normal mode (test bit 0), characters strobed on `rx_valid` are returned in arrival order by reads of the data register at offset 0x00, one per read. A data read while the receive FIFO is empty returns 0 and changes no state.
- R2: The flag register at 0x18 reads bit 4 = receive FIFO empty, bit 5 = transmit FIFO full, bit 6 = receive FIFO full, bit 7 = transmit FIFO empty; all other bits read 0.
- R3: The level-select register at 0x34 holds a 3-bit code in bits [5:3], reset value 2. The codes 0, 1, 2, 3 and 4 set the trigger level to DEPTH/8, DEPTH/4, DEPTH/2, 3·DEPTH/4 and 7·DEPTH/8 entries; codes 5 to 7 act as DEPTH/2.
- R4: Raw status (0x3C) bit 4 sets in the same edge where the fill count, compared against the current trigger, changes from below to at-or-above. It then holds until cleared, and falls by itself as soon as the count drops below the trigger.
- R5: Raw status bit 6 sets on the TIMEOUT-th `tick` after the last accepted push or pop, if at that point the FIFO holds at least one character but fewer than the trigger level. A push or a pop restarts the count. The bit falls when the FIFO becomes empty.
- R6: A push into a full receive FIFO, from either source, drops the character and sets raw status bit 10. When both sources push in one cycle, the deserializer character is taken first.
- R7: Writing the clear register at 0x44 clears each of raw bits 4, 6 and 10 that has a 1 in the written value and leaves the others. A new set event in the same cycle wins over the clear.
- R8: The mask register at 0x38 stores bits 4, 6 and 10, where 1 enables the matching source. The masked status register at 0x40 reads raw AND mask, and `irq` is high exactly when any masked bit is set.
- R9: The test-control register at 0x80 bit 1 selects test mode. In test mode, a data write pushes its low byte into the receive FIFO, and a data read pops the transmit FIFO (0 when it is empty). In normal mode, a data write pushes the transmit FIFO.
- R10: After reset the receive and transmit FIFOs are empty, raw status and mask are 0, the level code is 2, test mode is off and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is on `rx_data` |
| rx_data | input | 8 | Received character |
| tick | input | 1 | Bit-clock tick that advances the idle timer |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the access cycle |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong fill count or pointer shows at the ports on the next data or flag read. It also shows at once in the level bit and `irq`, because both are recomputed from the next count in the same edge. A timer that restarts on the wrong event, or counts wrong, moves the timeout bit by at least one cycle. Because the bench compares `irq` and every read against its model on each clock, that shift is reported within the idle window. A dropped-character mistake shows in the overrun bit one edge after the push into a full FIFO.

// File: rtl/uart_rx_irq.sv
module uart_rx_irq #(
  parameter int DEPTH    = 16,
  parameter int TX_DEPTH = 4,
  parameter int TIMEOUT  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int TAW = $clog2(TX_DEPTH);
  localparam int TCW = TAW + 1;
  localparam int TMW = $clog2(TIMEOUT + 1);

  localparam logic [7:0] A_DATA = 8'h00, A_FLAG = 8'h18, A_LVL = 8'h34, A_MASK = 8'h38,
                         A_RAW = 8'h3C, A_MIS = 8'h40, A_CLR = 8'h44, A_TEST = 8'h80;

  function automatic logic [CW-1:0] trig_of(input logic [2:0] code);
    case (code)
      3'd0:    trig_of = CW'(DEPTH / 8);
      3'd1:    trig_of = CW'(DEPTH / 4);
      3'd3:    trig_of = CW'(3 * DEPTH / 4);
      3'd4:    trig_of = CW'(7 * DEPTH / 8);
      default: trig_of = CW'(DEPTH / 2);
    endcase
  endfunction

  logic [7:0]     rx_mem [DEPTH];
  logic [7:0]     tx_mem [TX_DEPTH];
  logic [AW-1:0]  rx_wp, rx_rp;
  logic [CW-1:0]  rx_cnt, rx_cnt_nxt;
  logic [TAW-1:0] tx_wp, tx_rp;
  logic [TCW-1:0] tx_cnt;
  logic [TMW-1:0] tmo_q;
  logic [2:0]     lvl_q, lvl_nxt, mask_q;
  logic           test_q, cond_q, cond_nxt;
  logic           lvl_irq, rt_irq, ovr_irq;

  wire rd       = bus_sel & ~bus_we;
  wire wr       = bus_sel & bus_we;
  wire data_rd  = rd & (bus_addr == A_DATA);
  wire data_wr  = wr & (bus_addr == A_DATA);
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == CW'(DEPTH));
  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == TCW'(TX_DEPTH));

  wire rx_pop   = data_rd & ~test_q & ~rx_empty;
  wire bus_push = data_wr & test_q;
  wire acc0     = rx_valid & ~rx_full;
  wire acc1     = bus_push & ((rx_cnt + CW'(acc0)) != CW'(DEPTH));
  wire dropped  = (rx_valid & ~acc0) | (bus_push & ~acc1);
  wire tx_push  = data_wr & ~test_q & ~tx_full;
  wire tx_pop   = data_rd & test_q & ~tx_empty;
  wire moved    = acc0 | acc1 | rx_pop;

  wire [10:0] clr = (wr && bus_addr == A_CLR) ? bus_wdata[10:0] : 11'd0;

  assign rx_cnt_nxt = rx_cnt + CW'(acc0) + CW'(acc1) - CW'(rx_pop);
  assign lvl_nxt    = (wr && bus_addr == A_LVL) ? bus_wdata[5:3] : lvl_q;
  assign cond_nxt   = rx_cnt_nxt >= trig_of(lvl_nxt);

  wire fire = tick & ~moved & (tmo_q == TMW'(TIMEOUT - 1)) & (rx_cnt_nxt != '0) & ~cond_nxt;

  wire [31:0] raw  = {21'd0, ovr_irq, 3'd0, rt_irq, 1'b0, lvl_irq, 4'd0};
  wire [31:0] mask = {21'd0, mask_q[2], 3'd0, mask_q[1], 1'b0, mask_q[0], 4'd0};
  assign irq = |(raw & mask);

  logic unused_bits;
  assign unused_bits = ^bus_wdata[31:11];

  always_ff @(posedge clk) begin
    if (acc0) rx_mem[rx_wp] <= rx_data;
    if (acc1) rx_mem[rx_wp + AW'(acc0)] <= bus_wdata[7:0];
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      tmo_q <= '0; lvl_q <= 3'd2; mask_q <= '0; test_q <= 1'b0; cond_q <= 1'b0;
      lvl_irq <= 1'b0; rt_irq <= 1'b0; ovr_irq <= 1'b0;
    end else begin
      rx_wp  <= rx_wp + AW'(acc0) + AW'(acc1);
      rx_rp  <= rx_rp + AW'(rx_pop);
      rx_cnt <= rx_cnt_nxt;
      tx_wp  <= tx_wp + TAW'(tx_push);
      tx_rp  <= tx_rp + TAW'(tx_pop);
      tx_cnt <= tx_cnt + TCW'(tx_push) - TCW'(tx_pop);
      lvl_q  <= lvl_nxt;
      cond_q <= cond_nxt;
      if (wr && bus_addr == A_MASK) mask_q <= {bus_wdata[10], bus_wdata[6], bus_wdata[4]};
      if (wr && bus_addr == A_TEST) test_q <= bus_wdata[1];
      if (moved || rx_cnt_nxt == '0) tmo_q <= '0;
      else if (tick && tmo_q != TMW'(TIMEOUT)) tmo_q <= tmo_q + 1'b1;
      lvl_irq <= cond_nxt & ((lvl_irq & ~clr[4]) | ~cond_q);
      rt_irq  <= (rx_cnt_nxt != '0) & ((rt_irq & ~clr[6]) | fire);
      ovr_irq <= (ovr_irq & ~clr[10]) | dropped;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = test_q ? (tx_empty ? 32'd0 : {24'd0, tx_mem[tx_rp]})
                                  : (rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]});
      A_FLAG:  bus_rdata = {24'd0, tx_empty, rx_full, tx_full, rx_empty, 4'd0};
      A_LVL:   bus_rdata = {26'd0, lvl_q, 3'd0};
      A_MASK:  bus_rdata = mask;
      A_RAW:   bus_rdata = raw;
      A_MIS:   bus_rdata = raw & mask;
      A_TEST:  bus_rdata = {30'd0, test_q, 1'b0};
      default: bus_rdata = 32'd0;
    endcase
  end

  p_empty_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !test_q && rx_empty && !rx_valid) |=> rx_cnt == '0);
  p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !test_q && rx_empty) |-> bus_rdata == 32'd0);
  p_level_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_irq |-> rx_cnt >= trig_of(lvl_q));
  p_timeout_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rt_irq |-> !rx_empty);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full) |=> ovr_irq);
  p_clear_rt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_CLR && bus_wdata[6] && !tick) |=> !rt_irq);
  p_masked_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 3'd0) |-> !irq);
  p_test_no_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && data_rd && !rx_valid) |=> $stable(rx_cnt));
endmodule

// File: tb/uart_rx_irq_test.sv
`timescale 1ns/1ps
module uart_rx_irq_test;
  localparam int D = 16, TXD = 4, TO = 32;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, tick = 0, bus_sel = 0, bus_we = 0;
  logic [7:0] rx_data = 0, bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;

  uart_rx_irq #(.DEPTH(D), .TX_DEPTH(TXD), .TIMEOUT(TO)) uut (
    .clk, .rst_n, .rx_valid, .rx_data, .tick, .bus_sel, .bus_we,
    .bus_addr, .bus_wdata, .bus_rdata, .irq);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  byte unsigned rxq[$], txq[$];
  int m_code = 2, m_tmo = 0;
  logic [31:0] m_mask = 0;
  bit m_test = 0, m_cond = 0, m_lvl = 0, m_rt = 0, m_ovr = 0;

  function automatic int trig(int c);
    case (c)
      0: return D / 8;
      1: return D / 4;
      3: return 3 * D / 4;
      4: return 7 * D / 8;
      default: return D / 2;
    endcase
  endfunction

  function automatic logic [31:0] m_raw();
    return (32'(m_lvl) << 4) | (32'(m_rt) << 6) | (32'(m_ovr) << 10);
  endfunction

  function automatic logic [31:0] exp_rd();
    case (bus_addr)
      8'h00: if (m_test) return txq.size() ? 32'(txq[0]) : 0;
             else return rxq.size() ? 32'(rxq[0]) : 0;
      8'h18: return (32'(rxq.size() == 0) << 4) | (32'(txq.size() == TXD) << 5) |
                    (32'(rxq.size() == D) << 6) | (32'(txq.size() == 0) << 7);
      8'h34: return 32'(m_code) << 3;
      8'h38: return m_mask;
      8'h3C: return m_raw();
      8'h40: return m_raw() & m_mask;
      8'h80: return 32'(m_test) << 1;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of();
    case (bus_addr)
      8'h00: return m_test ? "R9" : "R1";
      8'h18: return "R2";
      8'h34: return "R3";
      8'h3C: return "R4 R5 R6 R7";
      8'h80: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic model_update();
    int n = rxq.size();
    bit rd = bus_sel && !bus_we, wr = bus_sel && bus_we;
    bit d0 = bus_addr == 8'h00;
    bit popr = rd && d0 && !m_test && n > 0;
    bit popt = rd && d0 && m_test && txq.size() > 0;
    bit a0 = rx_valid && n < D;
    bit bp = wr && d0 && m_test;
    bit a1 = bp && (n + int'(a0)) < D;
    bit dropped = (rx_valid && !a0) || (bp && !a1);
    logic [31:0] clr = (wr && bus_addr == 8'h44) ? bus_wdata : 0;
    int nn;
    bit newcond, act, fire;
    if (a0) rxq.push_back(rx_data);
    if (a1) rxq.push_back(bus_wdata[7:0]);
    if (popr) void'(rxq.pop_front());
    if (popt) void'(txq.pop_front());
    if (wr && d0 && !m_test && txq.size() < TXD) txq.push_back(bus_wdata[7:0]);
    if (wr && bus_addr == 8'h34) m_code = int'(bus_wdata[5:3]);
    if (wr && bus_addr == 8'h38) m_mask = bus_wdata & 32'h450;
    if (wr && bus_addr == 8'h80) m_test = bus_wdata[1];
    nn = rxq.size();
    newcond = nn >= trig(m_code);
    m_lvl = newcond && ((m_lvl && !clr[4]) || !m_cond);
    m_cond = newcond;
    act = a0 || a1 || popr;
    fire = tick && !act && m_tmo == TO - 1 && nn != 0 && !newcond;
    m_rt = nn != 0 && ((m_rt && !clr[6]) || fire);
    if (act || nn == 0) m_tmo = 0;
    else if (tick && m_tmo < TO) m_tmo++;
    m_ovr = (m_ovr && !clr[10]) || dropped;
  endtask

  task automatic step(string tag = "");
    #2;
    if (bus_sel && !bus_we)
      check(tag == "" ? tag_of() : tag, $sformatf("read %h", bus_addr), bus_rdata, exp_rd());
    check(tag == "" ? "R8" : tag, "irq", 32'(irq), 32'(|(m_raw() & m_mask)));
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic quiet();
    rx_valid = 0; bus_sel = 0; bus_we = 0; tick = 0;
  endtask

  task automatic idle(int n, bit tk);
    for (int i = 0; i < n; i++) begin quiet(); tick = tk; step(); end
  endtask

  task automatic rx(byte unsigned c);
    quiet(); rx_valid = 1; rx_data = c; step();
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    quiet(); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; step();
  endtask

  task automatic br(logic [7:0] a, string tag = "");
    quiet(); bus_sel = 1; bus_we = 0; bus_addr = a; step(tag);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    br(8'h18, "R10"); br(8'h34, "R10"); br(8'h3C, "R10");
    br(8'h38, "R10"); br(8'h80, "R10"); br(8'h00, "R10");
    // R1 ordering and empty read
    rx(8'h41); rx(8'h42); rx(8'h43);
    br(8'h18); br(8'h00); br(8'h00); br(8'h00); br(8'h00); br(8'h18);
    // R5 timeout with level 1/8 (trigger 2), R8 mask
    bw(8'h34, 32'h0 << 3); bw(8'h38, 32'h450);
    rx(8'h11); idle(TO - 1, 1); br(8'h3C); idle(1, 1); br(8'h3C); br(8'h40);
    rx(8'h12); br(8'h3C); br(8'h00); br(8'h3C);
    // R7 clear while still above level
    rx(8'h13); rx(8'h14); br(8'h3C); bw(8'h44, 32'h7FF); br(8'h3C);
    br(8'h00); br(8'h00); br(8'h3C); br(8'h00); br(8'h3C);
    // R3 all level codes
    for (int c = 0; c < 8; c++) begin
      bw(8'h34, 32'(c) << 3); bw(8'h44, 32'h7FF);
      for (int k = 0; k < D; k++) begin rx(8'(k + c)); br(8'h3C); end
      // R6 overrun
      rx(8'hEE); br(8'h3C); br(8'h18);
      for (int k = 0; k < D + 1; k++) br(8'h00);
      br(8'h3C); bw(8'h44, 32'h400); br(8'h3C);
    end
    // R9 test mode
    bw(8'h00, 32'hA1); bw(8'h00, 32'hA2); br(8'h18);
    bw(8'h80, 32'h2); br(8'h80);
    bw(8'h00, 32'h55);
    quiet(); rx_valid = 1; rx_data = 8'h66; bus_sel = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'h77; step();
    br(8'h00); br(8'h00); br(8'h00); br(8'h18);
    bw(8'h80, 32'h0);
    br(8'h00); br(8'h00); br(8'h00); br(8'h00);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] addrs [8] = '{8'h00, 8'h18, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h80};
      rx_valid = ($urandom % 3) == 0;
      rx_data = 8'($urandom);
      tick = ($urandom % 4) != 0;
      bus_sel = ($urandom % 3) != 0;
      bus_addr = addrs[$urandom % 8];
      bus_we = ($urandom % 3) == 0;
      if (bus_addr == 8'h80) bus_we = ($urandom % 8) == 0;
      bus_wdata = $urandom;
      step();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule